// File: doc/BRIEF.md
# Multi-port Ethernet reset sequencer

This controller brings a group of Ethernet port instances out of reset in a fixed order. A start request raises one reset line that goes to every port at once. The line stays high for at least a minimum number of cycles, and until every port has answered with its active-low reset acknowledge. The sequencer then releases the line. It visits the ports by ascending index, and for each one it waits first for transmit-lane stability and then for receive-PCS readiness.

A port's ready bit is set once both of its checks have passed. A single registered all-ready flag follows once every port is ready. Every wait has a cycle budget. If a budget runs out, the sequencer records a sticky per-port error bit and restarts the whole sequence from reset assertion. The error bits clear only on a new start request.

Top module: `eth_rst_seq`

## Requirements
- R1: After the asynchronous reset, `port_rst_o`, `port_rdy_o`, `all_rdy_o` and `port_err_o` are all 0, and they stay 0 until `start_i` is seen.
- R2: On the clock edge that samples `start_i` high, the sequencer enters the reset phase from any state and clears `port_rdy_o`, `all_rdy_o` and `port_err_o`. From that edge on, `port_rst_o` is 1.
- R3: A reset phase keeps `port_rst_o` high for at least MIN_RST_CYC cycles, even when every acknowledge is already low. With MIN_RST_CYC=4, if all acknowledges go low D cycles into the phase, the high time is max(4, D+1) cycles.
- R4: `port_rst_o` falls only on the edge after every bit of `rst_ack_ni` has been sampled low (low means acknowledged).
- R5: Ports are confirmed one at a time in ascending index order. For the current port, `tx_stable_i` must be seen high before `rx_ready_i` is examined. A port's `rx_ready_i` that is high while its TX check is still pending has no effect.
- R6: `port_rdy_o[i]` rises on the edge that samples `rx_ready_i[i]` high while port i is in its RX check. Each check takes at least one cycle, so when all flags are already high, port i is ready 2*(i+1) cycles after the reset line falls.
- R7: `all_rdy_o` is a register that rises one cycle after the last `port_rdy_o` bit. It is never 1 unless every ready bit is 1.
- R8: If a TX or RX wait lasts TIMEOUT_CYC cycles without its flag, then on that edge the current port's bit in `port_err_o` is set, `port_rdy_o` is cleared and `port_rst_o` rises again. The sequence restarts from the reset phase, and the error bit persists until the next start request.
- R9: If a reset phase lasts TIMEOUT_CYC cycles without all acknowledges, then on that edge `port_err_o` gains a bit for every port whose acknowledge is still high. `port_rst_o` stays high and a new full reset phase begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start (or restart) request, sampled each cycle |
| rst_ack_ni | input | N_PORTS | Per-port reset acknowledge, low = acknowledged |
| tx_stable_i | input | N_PORTS | Per-port transmit lanes stable |
| rx_ready_i | input | N_PORTS | Per-port receive PCS ready |
| port_rst_o | output | 1 | Global reset to all ports |
| port_rdy_o | output | N_PORTS | Per-port ready, bit i = port i |
| all_rdy_o | output | 1 | Registered all-ports-ready flag |
| port_err_o | output | N_PORTS | Sticky per-port timeout flags |

## Verification
Every output is due a fixed number of edges after its cause. `port_rst_o` follows the sampling edge of `start_i` by one edge. A port's TX or RX step completes on the edge after its flag is present, and never sooner than one edge after the step began. `all_rdy_o` lags the last ready bit by one more edge, and a timeout shows exactly TIMEOUT_CYC edges after its wait began. The bench drives inputs and samples outputs on the falling edge, counts falling edges from each reset rise or fall, and compares each event's edge index with a value worked out by a max-of-arrival recurrence over the programmed flag delays.

// File: rtl/eth_rst_seq_pkg.sv
package eth_rst_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RST,
    S_TX,
    S_RX,
    S_DONE
  } seq_state_e;
endpackage

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
  parameter int CNT_W   = 8,
  parameter int MIN_CYC = 4,
  parameter int TMO_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic min_met_o,
  output logic tmo_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;
  localparam logic [CNT_W-1:0] MinLim = CNT_W'(MIN_CYC - 1);
  localparam logic [CNT_W-1:0] TmoLim = CNT_W'(TMO_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
  end

  assign min_met_o = cnt_q >= MinLim;
  assign tmo_o     = cnt_q == TmoLim;

  // timeout window must outlast the minimum reset hold (R9)
  p_tmo_after_min_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> min_met_o);
endmodule

// File: rtl/rst_seq_port_pick.sv
module rst_seq_port_pick #(
  parameter int N_PORTS = 4,
  parameter int IDX_W   = 2
) (
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [N_PORTS-1:0] ack_ni,
  input  logic [N_PORTS-1:0] tx_i,
  input  logic [N_PORTS-1:0] rx_i,
  output logic               all_ack_o,
  output logic [N_PORTS-1:0] pend_o,
  output logic               tx_sel_o,
  output logic               rx_sel_o,
  output logic               last_o
);
  assign all_ack_o = ~|ack_ni;
  assign pend_o    = ack_ni;
  assign tx_sel_o  = tx_i[idx_i];
  assign rx_sel_o  = rx_i[idx_i];
  assign last_o    = idx_i == IDX_W'(N_PORTS - 1);
endmodule

// File: rtl/eth_rst_seq.sv
module eth_rst_seq
  import eth_rst_seq_pkg::*;
#(
  parameter int N_PORTS     = 4,
  parameter int MIN_RST_CYC = 8,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [N_PORTS-1:0] rst_ack_ni,
  input  logic [N_PORTS-1:0] tx_stable_i,
  input  logic [N_PORTS-1:0] rx_ready_i,
  output logic               port_rst_o,
  output logic [N_PORTS-1:0] port_rdy_o,
  output logic               all_rdy_o,
  output logic [N_PORTS-1:0] port_err_o
);
  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  seq_state_e         state_q, state_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [N_PORTS-1:0] rdy_q, rdy_d, err_q, err_d;
  logic               all_rdy_q;
  logic               tmr_clr, min_met, tmo;
  logic               all_ack, tx_sel, rx_sel, last_port;
  logic [N_PORTS-1:0] ack_pend;

  rst_seq_timer #(
    .CNT_W  (CNT_W),
    .MIN_CYC(MIN_RST_CYC),
    .TMO_CYC(TIMEOUT_CYC)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .min_met_o(min_met),
    .tmo_o    (tmo)
  );

  rst_seq_port_pick #(
    .N_PORTS(N_PORTS),
    .IDX_W  (IDX_W)
  ) u_pick (
    .idx_i    (idx_q),
    .ack_ni   (rst_ack_ni),
    .tx_i     (tx_stable_i),
    .rx_i     (rx_ready_i),
    .all_ack_o(all_ack),
    .pend_o   (ack_pend),
    .tx_sel_o (tx_sel),
    .rx_sel_o (rx_sel),
    .last_o   (last_port)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    rdy_d   = rdy_q;
    err_d   = err_q;
    tmr_clr = 1'b0;
    if (start_i) begin
      state_d = S_RST;
      idx_d   = '0;
      rdy_d   = '0;
      err_d   = '0;
      tmr_clr = 1'b1;
    end else begin
      unique case (state_q)
        S_RST: begin
          if (min_met && all_ack) begin
            state_d = S_TX;
            idx_d   = '0;
            tmr_clr = 1'b1;
          end else if (tmo) begin
            err_d   = err_q | ack_pend;
            tmr_clr = 1'b1;
          end
        end
        S_TX, S_RX: begin
          if ((state_q == S_TX) ? tx_sel : rx_sel) begin
            tmr_clr = 1'b1;
            if (state_q == S_TX) begin
              state_d = S_RX;
            end else begin
              rdy_d[idx_q] = 1'b1;
              if (last_port) state_d = S_DONE;
              else begin
                state_d = S_TX;
                idx_d   = idx_q + 1'b1;
              end
            end
          end else if (tmo) begin
            err_d[idx_q] = 1'b1;
            rdy_d        = '0;
            state_d      = S_RST;
            tmr_clr      = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      idx_q     <= '0;
      rdy_q     <= '0;
      err_q     <= '0;
      all_rdy_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      rdy_q     <= rdy_d;
      err_q     <= err_d;
      all_rdy_q <= start_i ? 1'b0 : &rdy_q;
    end
  end

  assign port_rst_o = state_q == S_RST;
  assign port_rdy_o = rdy_q;
  assign all_rdy_o  = all_rdy_q;
  assign port_err_o = err_q;

  // length of the current reset pulse, for the hold check
  logic [CNT_W-1:0] rst_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rst_len_q <= '0;
    else if (!port_rst_o) rst_len_q <= '0;
    else if (rst_len_q != CNT_W'(MIN_RST_CYC)) rst_len_q <= rst_len_q + 1'b1;
  end

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> port_rst_o && port_rdy_o == '0 && !all_rdy_o && port_err_o == '0);
  p_min_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(port_rst_o) |-> rst_len_q >= CNT_W'(MIN_RST_CYC));
  p_ack_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(port_rst_o) |-> $past(~|rst_ack_ni));
  p_in_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((port_rdy_o + N_PORTS'(1)) & port_rdy_o) == '0);
  p_rdy_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(port_rdy_o & ~$past(port_rdy_o)) != 0 |-> $past(|(rx_ready_i & ~port_rdy_o)));
  p_all_rdy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_rdy_o |-> &port_rdy_o);
  p_retry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_rst_o |-> port_rdy_o == '0);
  p_err_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(port_err_o & ~$past(port_err_o))) |-> port_rst_o);
endmodule

// File: tb/eth_rst_seq_tb.sv
module eth_rst_seq_tb;
  localparam int N   = 3;
  localparam int MIN = 4;
  localparam int TMO = 12;
  localparam int NEVER = 1000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N-1:0] ack_n = '1, tx = '0, rx = '0;
  logic port_rst, all_rdy;
  logic [N-1:0] rdy, err;

  int checks = 0, errs = 0;
  int tx_at[N], rx_at[N], got_rdy[N], exp_rdy[N];
  int got_all, got_back, exp_all;

  always #5 clk = ~clk;

  eth_rst_seq #(.N_PORTS(N), .MIN_RST_CYC(MIN), .TIMEOUT_CYC(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rst_ack_ni(ack_n),
    .tx_stable_i(tx), .rx_ready_i(rx), .port_rst_o(port_rst),
    .port_rdy_o(rdy), .all_rdy_o(all_rdy), .port_err_o(err));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); ack_n = '1; tx = '0; rx = '0; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // count high cycles of the reset line; acks drop d cycles in, except masked ports
  task automatic reset_phase(input int d, input logic [N-1:0] never, output int len);
    len = 0;
    while (port_rst && len < 200) begin
      ack_n = (len >= d) ? never : '1;
      len++;
      @(negedge clk);
    end
  endtask

  task automatic run_ports();
    for (int i = 0; i < N; i++) got_rdy[i] = -1;
    got_all = -1; got_back = -1;
    for (int m = 0; m < 150; m++) begin
      if (port_rst) begin got_back = m; break; end
      for (int i = 0; i < N; i++) if (got_rdy[i] < 0 && rdy[i]) got_rdy[i] = m;
      if (all_rdy) begin got_all = m; break; end
      for (int i = 0; i < N; i++) begin
        tx[i] = (m >= tx_at[i]);
        rx[i] = (m >= rx_at[i]);
      end
      @(negedge clk);
    end
  endtask

  task automatic predict();
    int e0, etx;
    e0 = 0;
    for (int i = 0; i < N; i++) begin
      etx = (e0 + 1 > tx_at[i] + 1) ? e0 + 1 : tx_at[i] + 1;
      exp_rdy[i] = (etx + 1 > rx_at[i] + 1) ? etx + 1 : rx_at[i] + 1;
      e0 = exp_rdy[i];
    end
    exp_all = e0 + 1;
  endtask

  task automatic check_run(input string tag);
    predict();
    run_ports();
    for (int i = 0; i < N; i++)
      chk(got_rdy[i] == exp_rdy[i], tag, $sformatf("ready cycle port %0d", i), got_rdy[i], exp_rdy[i]);
    chk(got_all == exp_all, "R7", "all-ready cycle", got_all, exp_all);
  endtask

  initial begin
    int len;
    repeat (3) @(negedge clk);
    // R1: idle after reset
    chk(port_rst == 0 && rdy == 0 && all_rdy == 0 && err == 0, "R1", "reset outputs", {port_rst, rdy, all_rdy, err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(port_rst == 0 && rdy == 0, "R1", "idle without start", {port_rst, rdy}, 0);

    // R3/R4 sweep over acknowledge delay, all flags present at once (R6)
    for (int d = 0; d <= 8; d++) begin
      pulse_start();
      chk(port_rst == 1 && rdy == 0 && all_rdy == 0 && err == 0, "R2", "start enters reset", {port_rst, rdy, all_rdy, err}, 1 << (2*N + 1));
      reset_phase(d, '0, len);
      chk(len == ((MIN > d + 1) ? MIN : d + 1), "R3", $sformatf("reset length d=%0d", d), len, (MIN > d + 1) ? MIN : d + 1);
      for (int i = 0; i < N; i++) begin tx_at[i] = 0; rx_at[i] = 0; end
      check_run("R6");
    end

    // R4: one port late to acknowledge holds the release
    pulse_start();
    reset_phase(0, 3'b010, len);
    chk(len == 200, "R4", "no release while one ack high", len, 200);
    chk(port_rst == 1, "R4", "reset still high", port_rst, 1);

    // R5: staggered flags, RX often earlier than TX
    for (int p = 0; p < 6; p++) begin
      pulse_start();
      reset_phase(1, '0, len);
      for (int i = 0; i < N; i++) begin
        tx_at[i] = (p * 3 + i * 5) % 10;
        rx_at[i] = (p * 7 + i * 2) % 11;
      end
      check_run("R5");
    end

    // R8: port 1 never reports TX stable
    pulse_start();
    reset_phase(0, '0, len);
    tx_at[0] = 0; rx_at[0] = 0; tx_at[1] = NEVER; rx_at[1] = 0; tx_at[2] = 0; rx_at[2] = 0;
    run_ports();
    chk(got_back == 2 + TMO, "R8", "timeout cycle", got_back, 2 + TMO);
    chk(err == 3'b010, "R8", "error bit", err, 3'b010);
    chk(rdy == 0, "R8", "ready cleared on retry", rdy, 0);
    reset_phase(0, '0, len);
    chk(len == MIN, "R3", "retry reset holds minimum with acks low", len, MIN);
    tx_at[1] = 0;
    check_run("R8");
    chk(err == 3'b010, "R8", "error sticky after success", err, 3'b010);

    // R9: port 2 never acknowledges in the first reset period
    pulse_start();
    chk(err == 0, "R2", "start clears errors", err, 0);
    for (int k = 0; k < TMO; k++) begin
      ack_n = 3'b100;
      @(negedge clk);
      if (k == TMO - 2) chk(err == 0, "R9", "no error before timeout", err, 0);
    end
    chk(err == 3'b100 && port_rst == 1, "R9", "reset timeout flags port 2", {err, port_rst}, {3'b100, 1'b1});
    reset_phase(0, '0, len);
    chk(len == MIN, "R9", "new full reset period", len, MIN);
    for (int i = 0; i < N; i++) begin tx_at[i] = 0; rx_at[i] = 0; end
    check_run("R9");

    // R7: start clears all-ready
    chk(all_rdy == 1, "R7", "all ready held", all_rdy, 1);
    pulse_start();
    chk(all_rdy == 0 && rdy == 0, "R7", "start clears ready", {all_rdy, rdy}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule